// File: doc/BRIEF.md
# Multiplexed LCD drive sequencer

This block produces the timing and the per-pin voltage selection for a segment LCD with up to four backplanes and a parameterised number of segment lines. Each pin receives a 2-bit code that picks one of four supply levels. An analog stage outside the block turns the code into a voltage. A frame is divided into equal time slots, one for each backplane in use. In its slot a backplane is pulled to an extreme level. Each segment then drives either the opposite extreme (lit) or a level that keeps the voltage across the element small (dark). Polarity flips on every other frame, so each element sees no net DC.

The display memory sits outside the block. It is read through a column address that always points at the slot that comes next. The block captures that column in a latch on the last cycle of the current slot and drives it for the whole of the following slot. Drive mode, bias and power saving are requested on input pins. A new request is adopted only where one frame ends and the next begins, and slot numbering then restarts at zero. The frame start and the slot number are brought out with the drive codes.

Top module: `lcd_mux_drive`

## Requirements
- R1: While reset is asserted, every backplane and segment code is 0 (VDD) and frame_start is low. The first frame after reset runs in 1:4 multiplex with 1/3 bias and normal timing, whatever the request inputs hold.
- R2: Level codes are 0 = VDD, 1 = VDD−Vop/3, 2 = VDD−2Vop/3 and 3 = VLCD. With 1/2 bias, code 1 is the midpoint between VDD and VLCD. Backplane pin j uses bp_lvl[2j+1:2j] and segment i uses seg_lvl[2i+1:2i].
- R3: mode_req values 0, 1, 2 and 3 select static, 1:2, 1:3 and 1:4 operation, using backplanes 0 up to mode_req. slot_idx steps 0, 1, … up to the mode value and then wraps to 0. Backplanes above the mode value stay at code 0.
- R4: A frame lasts NORM_DIV clock cycles in normal timing and NORM_DIV/SAVE_RATIO cycles with power saving. All slots in a frame are the same length.
- R5: In 1:2, 1:3 or 1:4 mode with 1/3 bias, during a non-inverted frame: the slot's backplane drives 0 and the other backplanes in use drive 2; lit segments drive 3 and dark segments drive 1.
- R6: Frames alternate between non-inverted and inverted, starting with non-inverted after reset. In an inverted frame, static and 1/3-bias codes become 3 minus the non-inverted code.
- R7: In a multiplex mode with 1/2 bias, the slot's backplane drives 0 (non-inverted) or 3 (inverted), and the other backplanes in use drive 1 in both frames. A lit segment drives the extreme opposite to the slot's backplane. A dark segment drives the same extreme as the slot's backplane.
- R8: In static mode, backplane 0 drives 0 and 3 in alternate frames. A lit segment drives the opposite level and a dark segment drives the same level. The bias input has no effect.
- R9: col_addr names the slot that follows the current one. col_data is sampled only on the last cycle of a slot and is shown throughout the next slot, with segment i taken from bit i. Changes earlier in the slot have no effect. The latch is empty after reset.
- R10: Changes to mode_req, half_bias_req and psave_req take effect only at a frame boundary. The new frame starts at slot 0.
- R11: The drive codes, frame_start and slot_idx all come from registers and are aligned with each other. frame_start is a one-cycle pulse on the first cycle of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested drive mode (0 static … 3 1:4) |
| half_bias_req | input | 1 | Requested 1/2 bias (0 selects 1/3) |
| psave_req | input | 1 | Requested power-saving frame timing |
| col_data | input | NSEG | Memory column for the slot named by col_addr |
| col_addr | output | 2 | Slot whose column is fetched next |
| bp_lvl | output | 8 | Backplane level codes, 2 bits per pin |
| seg_lvl | output | 2*NSEG | Segment level codes, 2 bits per pin |
| frame_start | output | 1 | Pulse on the first cycle of a frame |
| slot_idx | output | 2 | Slot currently being driven |

## Verification
The bench builds the block with NSEG = 8, NORM_DIV = 144 and SAVE_RATIO = 6. Slot lengths then range from 6 to 144 cycles, and both divisors split evenly into one, two, three or four slots. This lets every mode, both biases, both polarities and power saving run through several whole frames in a short run. With only eight segments, a few distinct memory columns toggle every segment pin and give each backplane slot a different pattern. The short slots also let a mode request that arrives mid-frame, and a col_data glitch inside a slot, be checked at a precise cycle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int NBP = 4;
  localparam logic [1:0] MODE_RESET = 2'd3;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_TOP = 2'd0;
  localparam lvl_t LVL_UP  = 2'd1;
  localparam lvl_t LVL_LO  = 2'd2;
  localparam lvl_t LVL_BOT = 2'd3;

  // Mirror about the middle of the ladder on inverted frames.
  function automatic lvl_t flip(lvl_t c, logic inv);
    return inv ? ~c : c;
  endfunction

  function automatic lvl_t bp_code(logic in_slot, logic used, logic half, logic inv);
    if (!used)   return LVL_TOP;
    if (in_slot) return flip(LVL_TOP, inv);
    if (half)    return LVL_UP;
    return flip(LVL_LO, inv);
  endfunction

  function automatic lvl_t seg_code(logic on, logic two_level, logic inv);
    if (two_level) return flip(on ? LVL_BOT : LVL_TOP, inv);
    return flip(on ? LVL_BOT : LVL_UP, inv);
  endfunction
endpackage

// File: rtl/lcd_seq_timing.sv
module lcd_seq_timing
  import lcd_seq_pkg::*;
#(
  parameter int NORM_DIV   = 2880,
  parameter int SAVE_RATIO = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       half_req,
  input  logic       ps_req,
  output logic [1:0] slot_q,
  output logic [1:0] next_slot,
  output logic       slot_end,
  output logic       frame_end,
  output logic       first_cyc,
  output logic       pol_q,
  output logic [1:0] mode_q,
  output logic       half_q
);
  localparam int SAVE_DIV = NORM_DIV / SAVE_RATIO;
  localparam int CW       = $clog2(NORM_DIV);

  function automatic int slot_cycles(logic [1:0] m, logic ps);
    case (m)
      2'd0:    return ps ? SAVE_DIV     : NORM_DIV;
      2'd1:    return ps ? SAVE_DIV / 2 : NORM_DIV / 2;
      2'd2:    return ps ? SAVE_DIV / 3 : NORM_DIV / 3;
      default: return ps ? SAVE_DIV / 4 : NORM_DIV / 4;
    endcase
  endfunction

  logic [CW-1:0] cnt_q;
  logic          ps_q;

  assign slot_end  = (int'(cnt_q) == slot_cycles(mode_q, ps_q) - 1);
  assign frame_end = slot_end && (slot_q == mode_q);
  assign next_slot = (slot_q == mode_q) ? 2'd0 : slot_q + 2'd1;
  assign first_cyc = (cnt_q == '0) && (slot_q == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= 2'd0;
      pol_q  <= 1'b0;
      mode_q <= MODE_RESET;
      half_q <= 1'b0;
      ps_q   <= 1'b0;
    end else if (slot_end) begin
      cnt_q  <= '0;
      slot_q <= next_slot;
      if (frame_end) begin
        pol_q  <= ~pol_q;
        mode_q <= mode_req;
        half_q <= half_req;
        ps_q   <= ps_req;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_seq_latch.sv
module lcd_seq_latch #(
  parameter int NSEG = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NSEG-1:0] din,
  output logic [NSEG-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/lcd_seq_levels.sv
module lcd_seq_levels
  import lcd_seq_pkg::*;
#(
  parameter int NSEG = 40
) (
  input  logic [1:0]        slot,
  input  logic [1:0]        mode,
  input  logic              half,
  input  logic              inv,
  input  logic [NSEG-1:0]   col,
  output logic [2*NBP-1:0]  bp_nxt,
  output logic [2*NSEG-1:0] seg_nxt
);
  logic two_level;
  assign two_level = (mode == 2'd0) || half;

  for (genvar j = 0; j < NBP; j++) begin : g_bp
    assign bp_nxt[2*j +: 2] = bp_code(j == int'(slot), j <= int'(mode),
                                      half && (mode != 2'd0), inv);
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign seg_nxt[2*i +: 2] = seg_code(col[i], two_level, inv);
  end
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcd_seq_pkg::*;
#(
  parameter int NSEG       = 40,
  parameter int NORM_DIV   = 2880,
  parameter int SAVE_RATIO = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_req,
  input  logic              half_bias_req,
  input  logic              psave_req,
  input  logic [NSEG-1:0]   col_data,
  output logic [1:0]        col_addr,
  output logic [2*NBP-1:0]  bp_lvl,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic              frame_start,
  output logic [1:0]        slot_idx
);
  logic [1:0]        slot_q, next_slot, mode_q;
  logic              slot_end, frame_end, first_cyc, pol_q, half_q;
  logic [NSEG-1:0]   latch_q;
  logic [2*NBP-1:0]  bp_nxt;
  logic [2*NSEG-1:0] seg_nxt;

  lcd_seq_timing #(.NORM_DIV(NORM_DIV), .SAVE_RATIO(SAVE_RATIO)) u_timing (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .half_req(half_bias_req),
    .ps_req(psave_req), .slot_q(slot_q), .next_slot(next_slot),
    .slot_end(slot_end), .frame_end(frame_end), .first_cyc(first_cyc),
    .pol_q(pol_q), .mode_q(mode_q), .half_q(half_q)
  );

  lcd_seq_latch #(.NSEG(NSEG)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(slot_end), .din(col_data), .dout(latch_q)
  );

  lcd_seq_levels #(.NSEG(NSEG)) u_levels (
    .slot(slot_q), .mode(mode_q), .half(half_q), .inv(pol_q), .col(latch_q),
    .bp_nxt(bp_nxt), .seg_nxt(seg_nxt)
  );

  assign col_addr = next_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_lvl      <= '0;
      seg_lvl     <= '0;
      frame_start <= 1'b0;
      slot_idx    <= 2'd0;
    end else begin
      bp_lvl      <= bp_nxt;
      seg_lvl     <= seg_nxt;
      frame_start <= first_cyc;
      slot_idx    <= slot_q;
    end
  end
endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk #(
  parameter int NSEG = 40,
  parameter int NBP  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        slot_q,
  input logic [1:0]        mode_q,
  input logic              half_q,
  input logic              pol_q,
  input logic              slot_end,
  input logic              frame_end,
  input logic              frame_start,
  input logic [NSEG-1:0]   latch_q,
  input logic [2*NBP-1:0]  bp_nxt,
  input logic [2*NBP-1:0]  bp_lvl,
  input logic [2*NSEG-1:0] seg_lvl
);
  int   ext_cnt;
  logic unused_bad;

  always_comb begin
    ext_cnt    = 0;
    unused_bad = 1'b0;
    for (int j = 0; j < NBP; j++) begin
      if (j <= int'(mode_q)) begin
        if (bp_nxt[2*j +: 2] == 2'd0 || bp_nxt[2*j +: 2] == 2'd3) ext_cnt++;
      end else if (bp_nxt[2*j +: 2] != 2'd0) begin
        unused_bad = 1'b1;
      end
    end
  end

  AST_RESET_VDD:   assert property (@(posedge clk) !rst_n |-> (bp_lvl == '0 && seg_lvl == '0 && !frame_start)); // R1
  AST_SLOT_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) slot_q <= mode_q); // R3
  AST_UNUSED_BP:   assert property (@(posedge clk) disable iff (!rst_n) !unused_bad); // R3
  AST_ONE_EXTREME: assert property (@(posedge clk) disable iff (!rst_n) ext_cnt == 1); // R5
  AST_POL_FLIP:    assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> pol_q != $past(pol_q)); // R6
  AST_POL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !frame_end |=> $stable(pol_q)); // R6
  AST_LATCH_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !slot_end |=> $stable(latch_q)); // R9
  AST_CFG_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !frame_end |=> $stable({mode_q, half_q})); // R10
  AST_SLOT_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> slot_q == 2'd0); // R10
  AST_FS_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start); // R11
endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.NSEG(NSEG), .NBP(lcd_seq_pkg::NBP)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .mode_q(mode_q), .half_q(half_q),
  .pol_q(pol_q), .slot_end(slot_end), .frame_end(frame_end),
  .frame_start(frame_start), .latch_q(latch_q), .bp_nxt(bp_nxt),
  .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_mux_drive_bench.sv
`timescale 1ns/1ps
module lcd_mux_drive_bench;
  localparam int NSEG = 8;
  localparam int NDIV = 144;
  localparam int SRAT = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode_req = 2'd1;
  logic              half_bias_req = 1'b0;
  logic              psave_req = 1'b0;
  logic [NSEG-1:0]   col_data;
  logic [1:0]        col_addr;
  logic [7:0]        bp_lvl;
  logic [2*NSEG-1:0] seg_lvl;
  logic              frame_start;
  logic [1:0]        slot_idx;

  logic [NSEG-1:0] mem [0:3];
  logic            ovr_en = 1'b0;
  logic [NSEG-1:0] ovr_val = '0;
  assign col_data = ovr_en ? ovr_val : mem[col_addr];

  lcd_mux_drive #(.NSEG(NSEG), .NORM_DIV(NDIV), .SAVE_RATIO(SRAT)) u_lcd_mux_drive (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .half_bias_req(half_bias_req),
    .psave_req(psave_req), .col_data(col_data), .col_addr(col_addr),
    .bp_lvl(bp_lvl), .seg_lvl(seg_lvl), .frame_start(frame_start), .slot_idx(slot_idx)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench model state
  int       fcount = 0, off = 0;
  bit       have_prev = 0, mon_en = 0, e_pol = 0;
  bit [1:0] e_mode = 2'd3;
  bit       e_half = 0, e_ps = 0;
  bit [1:0] r_mode;
  bit       r_half, r_ps;

  always @(posedge clk) begin
    r_mode <= mode_req;
    r_half <= half_bias_req;
    r_ps   <= psave_req;
  end

  function automatic int frame_len(bit ps);
    return ps ? NDIV / SRAT : NDIV;
  endfunction

  // distance below VDD in sixths of Vop -> code
  function automatic logic [1:0] to_code(int sixths);
    case (sixths)
      0:       return 2'd0;
      2, 3:    return 2'd1;
      4:       return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic check_cycle();
    int slen, s, v, o2, s2;
    logic [NSEG-1:0] d;
    logic [7:0] eb;
    logic [2*NSEG-1:0] es;
    string tag;
    slen = frame_len(e_ps) / (int'(e_mode) + 1);
    s = off / slen;
    chk(int'(slot_idx) == s, "R3 slot", slot_idx, s);
    if (off == 0) chk(frame_start == 1'b1, "R11 strobe", frame_start, 1);
    d = (fcount == 1 && s == 0) ? '0 : mem[s];
    for (int j = 0; j < 4; j++) begin
      if (j > int'(e_mode)) eb[2*j +: 2] = 2'd0;
      else begin
        v = (j == s) ? 0 : ((e_half && e_mode != 0) ? 3 : 4);
        if (e_pol) v = 6 - v;
        eb[2*j +: 2] = to_code(v);
      end
    end
    for (int i = 0; i < NSEG; i++) begin
      v = d[i] ? 6 : ((e_mode == 0 || e_half) ? 0 : 2);
      if (e_pol) v = 6 - v;
      es[2*i +: 2] = to_code(v);
    end
    tag = (e_mode == 0) ? "R8" : (e_half ? "R7" : "R5");
    tag = e_pol ? {tag, " R6 R2"} : {tag, " R2"};
    chk(bp_lvl == eb, {tag, " backplanes"}, bp_lvl, eb);
    chk(seg_lvl == es, {tag, " segments R9"}, seg_lvl, es);
    o2 = off + 1;
    if (o2 < frame_len(e_ps)) begin
      s2 = o2 / slen;
      s2 = (s2 == int'(e_mode)) ? 0 : s2 + 1;
      chk(int'(col_addr) == s2, "R9 col_addr", col_addr, s2);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_start) begin
        if (have_prev && mon_en) chk(off + 1 == frame_len(e_ps), "R4 frame length", off + 1, frame_len(e_ps));
        if (fcount > 0) begin
          e_mode = r_mode; e_half = r_half; e_ps = r_ps;
        end
        e_pol = fcount[0];
        fcount++;
        off = 0;
        have_prev = 1;
      end else if (have_prev) off++;
      if (have_prev && mon_en) check_cycle();
    end
  end

  task automatic wait_frames(int n);
    int f0;
    f0 = fcount;
    while (fcount < f0 + n) @(negedge clk);
  endtask

  task automatic apply(bit [1:0] m, bit h, bit p, logic [NSEG-1:0] seed, int nfr);
    mon_en = 0;
    @(posedge clk); #2;
    mode_req = m; half_bias_req = h; psave_req = p;
    for (int k = 0; k < 4; k++) mem[k] = seed ^ NSEG'(8'h35 * (k + 1));
    wait_frames(2);
    mon_en = 1;
    wait_frames(nfr);
  endtask

  task automatic t_reset();
    int mx;
    for (int k = 0; k < 4; k++) mem[k] = NSEG'(8'hA1 + 8'h1F * k);
    repeat (3) begin
      @(negedge clk);
      chk(bp_lvl == '0 && seg_lvl == '0 && !frame_start, "R1 reset levels",
          {bp_lvl, seg_lvl}, 0);
    end
    rst_n = 1'b1;
    mon_en = 1;
    @(negedge clk);
    chk(frame_start == 1'b1 && slot_idx == 2'd0, "R1 R11 first frame", {frame_start, slot_idx}, 4);
    mx = 0;
    do begin
      @(negedge clk);
      if (int'(slot_idx) > mx) mx = int'(slot_idx);
    end while (!frame_start);
    chk(mx == 3, "R1 reset mode is 1:4", mx, 3);
    wait_frames(2);
  endtask

  task automatic t_override();
    mon_en = 1;
    wait_frames(1);
    @(posedge clk); #2;
    ovr_en = 1'b1; ovr_val = ~mem[1];
    repeat (5) @(posedge clk);
    #2 ovr_en = 1'b0;
    wait_frames(2);
  endtask

  task automatic t_switch();
    int mx;
    wait_frames(1);
    @(posedge clk); #2;
    mode_req = 2'd1;
    mx = 0;
    do begin
      @(negedge clk);
      if (!frame_start && int'(slot_idx) > mx) mx = int'(slot_idx);
    end while (!frame_start);
    chk(mx == 3, "R10 old mode kept to frame end", mx, 3);
    chk(slot_idx == 2'd0, "R10 restart at slot 0", slot_idx, 0);
    mx = 0;
    do begin
      @(negedge clk);
      if (!frame_start && int'(slot_idx) > mx) mx = int'(slot_idx);
    end while (!frame_start);
    chk(mx == 1, "R10 new mode in next frame", mx, 1);
  endtask

  initial begin
    t_reset();
    apply(2'd3, 0, 0, 8'h5A, 3);   // 1:4, 1/3 bias
    apply(2'd2, 0, 0, 8'hC3, 3);   // 1:3
    apply(2'd1, 0, 0, 8'h0F, 3);   // 1:2
    apply(2'd1, 1, 0, 8'h96, 3);   // 1:2, 1/2 bias
    apply(2'd3, 1, 0, 8'h3C, 2);   // 1:4, 1/2 bias
    apply(2'd0, 1, 0, 8'hE7, 3);   // static, bias ignored (R8)
    apply(2'd0, 0, 0, 8'h18, 2);
    apply(2'd3, 0, 1, 8'h71, 4);   // power saving (R4)
    apply(2'd2, 1, 1, 8'h2D, 4);
    apply(2'd3, 0, 0, 8'hB4, 1);
    t_override();                  // R9
    t_switch();                    // R10
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule